// File: doc/BRIEF.md
# Strip-Mined Strided Vector Address Generator

This block drives the memory side of a vector load/store unit. Given a vector of N elements, a base address and a stride, it produces one element address per handshake cycle. The addresses form the sequence base + index × stride, computed modulo 2^24. The vector register holds 64 elements, so a long vector is cut into strips. Each strip is announced together with the vector length that applies to it.

The short strip goes first. It holds N mod 64 elements, and every strip after it holds 64. When N is an exact multiple of 64 there is no short strip: the first strip is a full one. The index and the address run on without a break across strip boundaries. Markers flag the first and last element of every strip. A single-cycle done pulse closes the operation.

A consumer holds `ready` low to pause the stream. While paused, every output and internal count stays frozen. The length, base and stride are captured on the cycle `start` is accepted. A `start` that arrives while an operation is running is ignored.

Top module: `vec_strip_agen`

## Requirements
- R1: After reset, `out_valid` and `done` are both 0.
- R2: The first strip has VL = N mod 64 when that value is nonzero, and VL = 64 when N is a nonzero multiple of 64; a strip of length zero never appears.
- R3: Every strip after the first has VL = 64, so N = 200 gives four strips (8, 64, 64, 64), and exactly one of them is short.
- R4: Element i carries `addr` = (base + i × stride) mod 2^24. The stride is read as an unsigned 24-bit value, so a backward step is given as its two's complement. The sequence is continuous across strip boundaries.
- R5: `elem_idx` counts elements 0 to N−1 across the whole vector and advances by one on each accepted element.
- R6: `strip_first` is 1 exactly on position 0 of a strip. `strip_last` is 1 exactly on position VL−1 of a strip.
- R7: While `out_valid` is 1 and `ready` is 0, all outputs hold their values into the next cycle.
- R8: `done` is 1 for exactly one cycle, in the cycle after the final element is accepted. `out_valid` is 0 while `done` is 1.
- R9: A start with N = 0 produces `done` in the next cycle and no valid element.
- R10: The length, base and stride are sampled when `start` is accepted; a `start` while elements are still being emitted has no effect on the sequence.
- R11: While `out_valid` is 1, `strip_vl` lies in the range 1 to 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, accepted when no operation is running |
| total_len | input | 16 | Number of elements N |
| base_addr | input | 24 | Address of element 0 |
| stride | input | 24 | Unsigned step between consecutive elements |
| ready | input | 1 | Downstream accepts the current element |
| out_valid | output | 1 | An element address is presented |
| addr | output | 24 | Address of the current element |
| elem_idx | output | 16 | Global index of the current element |
| strip_vl | output | 7 | Vector length of the current strip |
| strip_first | output | 1 | Current element opens its strip |
| strip_last | output | 1 | Current element closes its strip |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first element appears one cycle after the `start` edge. After that, each output changes one cycle after an edge on which `ready` was high, and otherwise stays put. `done` rises one cycle after the final element is accepted and falls one cycle later. For N = 0 it rises one cycle after `start`. The bench drives its inputs and samples the outputs on the falling edge. It advances its model's element index only for cycles in which it drove `ready` high, so each comparison lines up with the edge that should have moved the design. The bench also counts strips and short strips as elements are accepted.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } agen_state_e;

    // Size of the leading strip: the remainder, or a full register when
    // the remainder is zero (no empty strip is ever produced).
    function automatic int unsigned lead_strip_len(input int unsigned n,
                                                   input int unsigned mvl);
        int unsigned r;
        r = n % mvl;
        return (r == 0) ? mvl : r;
    endfunction

endpackage

// File: rtl/vsa_strip_ctrl.sv
module vsa_strip_ctrl #(
    parameter int MVL   = 64,
    parameter int LEN_W = 16,
    parameter int VL_W  = $clog2(MVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [LEN_W-1:0] total_len,
    input  logic             step,
    output logic [VL_W-1:0]  strip_vl,
    output logic [VL_W-1:0]  strip_pos,
    output logic             at_strip_end,
    output logic             at_vec_end
);
    import vsa_pkg::*;

    localparam logic [VL_W-1:0]  FULL_VL  = VL_W'(MVL);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MVL);

    logic [VL_W-1:0]  vl_q;
    logic [VL_W-1:0]  pos_q;
    logic [LEN_W-1:0] rem_q;
    logic [VL_W-1:0]  lead_vl;

    assign lead_vl      = VL_W'(lead_strip_len(int'(total_len), MVL));
    assign at_strip_end = (pos_q == vl_q - 1'b1);
    assign at_vec_end   = at_strip_end && (rem_q == '0);
    assign strip_vl     = vl_q;
    assign strip_pos    = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q  <= '0;
            pos_q <= '0;
            rem_q <= '0;
        end else if (launch) begin
            vl_q  <= lead_vl;
            pos_q <= '0;
            rem_q <= total_len - LEN_W'(lead_vl);
        end else if (step) begin
            if (at_strip_end) begin
                pos_q <= '0;
                if (rem_q != '0) begin
                    vl_q  <= FULL_VL;
                    rem_q <= rem_q - FULL_LEN;
                end
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vsa_addr_acc.sv
module vsa_addr_acc #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;

    assign addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            stride_q <= '0;
        end else if (launch) begin
            addr_q   <= base_addr;
            stride_q <= stride;
        end else if (step) begin
            addr_q <= addr_q + stride_q;
        end
    end

endmodule

// File: rtl/vsa_elem_cnt.sv
module vsa_elem_cnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             step,
    output logic [LEN_W-1:0] idx
);
    logic [LEN_W-1:0] idx_q;

    assign idx = idx_q;

    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (launch) idx_q <= '0;
        else if (step)   idx_q <= idx_q + 1'b1;
    end

endmodule

// File: rtl/vec_strip_agen.sv
module vec_strip_agen #(
    parameter int ADDR_W = 24,
    parameter int MVL    = 64,
    parameter int LEN_W  = 16,
    parameter int VL_W   = $clog2(MVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  total_len,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic              ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  elem_idx,
    output logic [VL_W-1:0]   strip_vl,
    output logic              strip_first,
    output logic              strip_last,
    output logic              done
);
    import vsa_pkg::*;

    agen_state_e state_q, state_d;
    logic        accept, launch, step;
    logic [VL_W-1:0] pos;
    logic        strip_end, vec_end;

    assign accept = start && (state_q != ST_RUN);
    assign launch = accept && (total_len != '0);
    assign step   = (state_q == ST_RUN) && ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                if (accept) state_d = (total_len == '0) ? ST_FIN : ST_RUN;
                else        state_d = ST_IDLE;
            end
            ST_RUN: begin
                if (step && vec_end) state_d = ST_FIN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    vsa_strip_ctrl #(.MVL(MVL), .LEN_W(LEN_W), .VL_W(VL_W)) u_strip (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .total_len    (total_len),
        .step         (step),
        .strip_vl     (strip_vl),
        .strip_pos    (pos),
        .at_strip_end (strip_end),
        .at_vec_end   (vec_end)
    );

    vsa_addr_acc #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .base_addr (base_addr),
        .stride    (stride),
        .step      (step),
        .addr      (addr)
    );

    vsa_elem_cnt #(.LEN_W(LEN_W)) u_idx (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .step   (step),
        .idx    (elem_idx)
    );

    assign out_valid   = (state_q == ST_RUN);
    assign done        = (state_q == ST_FIN);
    assign strip_first = out_valid && (pos == '0);
    assign strip_last  = out_valid && strip_end;

endmodule

// File: rtl/vsa_checker.sv
module vsa_checker #(
    parameter int ADDR_W = 24,
    parameter int MVL    = 64,
    parameter int LEN_W  = 16,
    parameter int VL_W   = $clog2(MVL + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [LEN_W-1:0]  total_len,
    input logic              ready,
    input logic              out_valid,
    input logic [ADDR_W-1:0] addr,
    input logic [LEN_W-1:0]  elem_idx,
    input logic [VL_W-1:0]   strip_vl,
    input logic              strip_first,
    input logic              strip_last,
    input logic              done
);
    // R11
    vl_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (strip_vl != '0) && (strip_vl <= VL_W'(MVL)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ready) |=> out_valid && $stable(addr) && $stable(elem_idx)
                                  && $stable(strip_vl) && $stable(strip_first)
                                  && $stable(strip_last));

    // R5
    idx_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ready) |=> done || (elem_idx == $past(elem_idx) + 1'b1));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !(start && total_len == '0)) |=> !done);

    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // R3
    full_strip_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && strip_first && elem_idx != '0) |-> strip_vl == VL_W'(MVL));

    // R6
    strip_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ready && strip_last) |=> done || strip_first);

endmodule

bind vec_strip_agen vsa_checker #(
    .ADDR_W(ADDR_W), .MVL(MVL), .LEN_W(LEN_W), .VL_W(VL_W)
) u_vsa_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .total_len   (total_len),
    .ready       (ready),
    .out_valid   (out_valid),
    .addr        (addr),
    .elem_idx    (elem_idx),
    .strip_vl    (strip_vl),
    .strip_first (strip_first),
    .strip_last  (strip_last),
    .done        (done)
);

// File: tb/vec_strip_agen_test.sv
`timescale 1ns/1ps
module vec_strip_agen_test;
    localparam int AW = 24;
    localparam int LW = 16;
    localparam int VW = 7;
    localparam int MV = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [LW-1:0] total_len = '0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] stride = '0;
    logic          ready = 1'b0;
    logic          out_valid, strip_first, strip_last, done;
    logic [AW-1:0] addr;
    logic [LW-1:0] elem_idx;
    logic [VW-1:0] strip_vl;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vec_strip_agen uut (
        .clk(clk), .rst(rst), .start(start), .total_len(total_len),
        .base_addr(base_addr), .stride(stride), .ready(ready),
        .out_valid(out_valid), .addr(addr), .elem_idx(elem_idx),
        .strip_vl(strip_vl), .strip_first(strip_first),
        .strip_last(strip_last), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lead_len(input int n);
        return (n % MV == 0) ? MV : n % MV;
    endfunction

    function automatic int exp_vl(input int n, input int i);
        return (i < lead_len(n)) ? lead_len(n) : MV;
    endfunction

    function automatic int exp_pos(input int n, input int i);
        return (i < lead_len(n)) ? i : (i - lead_len(n)) % MV;
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b,
                                                input logic [AW-1:0] s, input int i);
        logic [AW-1:0] prod;
        prod = AW'(longint'(s) * longint'(i));
        return b + prod;
    endfunction

    task automatic run_vec(input int n, input logic [AW-1:0] b, input logic [AW-1:0] s,
                           input int pct, input int inject_at,
                           output int strips, output int shorts);
        int i = 0;
        bit prev_rdy = 1'b1;
        bit rdy;
        string atag;
        strips = 0;
        shorts = 0;
        @(negedge clk);
        start = 1'b1; total_len = LW'(n); base_addr = b; stride = s;
        ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: operands change after capture
        total_len = LW'($urandom); base_addr = AW'($urandom); stride = AW'($urandom);
        if (n == 0) begin
            check(done == 1'b1, "R9", "done", done, 1);
            check(out_valid == 1'b0, "R9", "valid", out_valid, 0);
            @(negedge clk);
            check(done == 1'b0, "R8", "done fall", done, 0);
            return;
        end
        while (i < n) begin
            atag = prev_rdy ? "R4" : "R7";
            check(out_valid == 1'b1, "R10", "valid", out_valid, 1);
            check(done == 1'b0, "R8", "done early", done, 0);
            check(addr == exp_addr(b, s, i), atag, "addr", addr, exp_addr(b, s, i));
            check(int'(elem_idx) == i, "R5", "idx", elem_idx, i);
            check(int'(strip_vl) == exp_vl(n, i), (i == 0) ? "R2" : "R3", "vl",
                  strip_vl, exp_vl(n, i));
            check(strip_first == (exp_pos(n, i) == 0), "R6", "first", strip_first,
                  exp_pos(n, i) == 0);
            check(strip_last == (exp_pos(n, i) == exp_vl(n, i) - 1), "R6", "last",
                  strip_last, exp_pos(n, i) == exp_vl(n, i) - 1);
            check(strip_vl >= 1 && strip_vl <= MV, "R11", "vl range", strip_vl, MV);
            if (i == inject_at) begin
                start = 1'b1; total_len = 16'd5; base_addr = 24'h0; stride = 24'h1;
            end else begin
                start = 1'b0;
            end
            rdy = (int'($urandom % 100) < pct);
            ready = rdy;
            if (rdy) begin
                if (exp_pos(n, i) == 0) begin
                    strips++;
                    if (exp_vl(n, i) != MV) shorts++;
                end
                i++;
            end
            prev_rdy = rdy;
            @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b1, "R8", "done", done, 1);
        check(out_valid == 1'b0, "R8", "valid at done", out_valid, 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done fall", done, 0);
        check(out_valid == 1'b0, "R10", "no restart", out_valid, 0);
    endtask

    initial begin
        int st, sh, dummy;
        dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);

        run_vec(0, 24'h123, 24'h1, 100, -1, st, sh);
        run_vec(200, 24'h000100, 24'h1, 100, -1, st, sh);
        check(st == 4, "R3", "strip count n200", st, 4);
        check(sh == 1, "R3", "short strips n200", sh, 1);
        run_vec(128, 24'h004000, 24'h4, 70, -1, st, sh);
        check(st == 2 && sh == 0, "R2", "n128 strips", st * 10 + sh, 20);
        run_vec(64, 24'h000010, 24'h8, 100, -1, st, sh);
        run_vec(1, 24'hABCDEF, 24'h3, 40, -1, st, sh);
        run_vec(65, 24'h000200, 24'h10, 60, -1, st, sh);
        // R4: backward stride wraps below zero
        run_vec(70, 24'h000010, 24'hFFFFFD, 50, -1, st, sh);
        // R4: forward wrap past the top
        run_vec(40, 24'hFFFFF0, 24'h3, 80, -1, st, sh);
        // R10: start during run ignored
        run_vec(150, 24'h001000, 24'h20, 75, 30, st, sh);

        for (int k = 0; k < 10; k++) begin
            int n = int'($urandom % 300);
            int pct = 30 + int'($urandom % 71);
            run_vec(n, AW'($urandom), AW'($urandom), pct,
                    int'($urandom % 400), st, sh);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule